// File: doc/BRIEF.md
# Hardware Trap Priority and Vector Unit

This unit sits next to a small processor core and turns exception pulses into vector requests. It accepts one-cycle pulses from three reset sources, from three urgent traps (non-maskable interrupt, stack overflow, stack underflow) and from five fault detectors (bad opcode, privileged-instruction fault, misaligned word operand, misaligned instruction fetch, external bus fault). It also accepts software trap requests that carry a 7-bit number. Every trap except a reset records itself in an 8-bit flag register. Software clears that register by writing ones.

Pending requests are ranked by trap level. Resets are level 3, the urgent traps are level 2 and the faults are level 1. A hardware request is issued only if its level is above the level of the service that is running. A software trap takes the running level as its own. The unit holds a stack of active levels. It pushes a level when the core accepts a vector and pops one when the core returns from a trap. While a hardware service is running or presented, the qualifier that allows ordinary interrupts is held low.

Vectors go to the core over a valid/ready interface. Once `vec_valid_o` is high, the address, number and level stay fixed until `vec_ready_i` is seen high on a clock edge. Software trap requests come in on a second valid/ready interface. `sw_ready_o` goes low while one request is waiting. It also goes low when the level stack has too little free room to take another software entry and still hold a full chain of hardware levels.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset, `vec_valid_o`=0, `flags_o`=0, `std_irq_ok_o`=1 and `sw_ready_o`=1.
- R2: Any bit of `rst_cause_i` yields one vector with number 0x00, address 0x000000 and level 3. No flag bit is set.
- R3: `cls_a_i[0]` (NMI) yields number 0x02, address 0x000008. `cls_a_i[1]` (stack overflow) yields 0x04, 0x000010. `cls_a_i[2]` (stack underflow) yields 0x06, 0x000018. All three run at level 2. When several are pending, the lowest bit index goes first and the others stay pending.
- R4: Any bit of `cls_b_i` yields number 0x0A, address 0x000028 at level 1. Faults that are pending together yield a single vector. Level 2 requests go before level 1 requests.
- R5: Flag bit positions are: [0] NMI, [1] stack overflow, [2] stack underflow, [3] bad opcode, [4] privileged fault, [5] misaligned operand, [6] misaligned fetch, [7] bus fault. A pulse sets its bit one cycle later, and the bit stays set until software clears it.
- R6: When `flag_clr_we_i`=1, each bit set in `flag_clr_mask_i` clears the matching flag and all other flags are kept. If a set pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R7: A hardware request whose level is above the running level is issued while that service is still active. In that case it preempts the service.
- R8: A request whose level is equal to or below the running level sets its flag but produces no vector. It is issued once `rett_i` has popped the stack to a lower level.
- R9: A software trap with number n yields address 4·n and the level that is running when it is issued. Any eligible hardware request goes before it.
- R10: A hardware request never presents a number in the range 0x0B to 0x0F.
- R11: `std_irq_ok_o` is 0 while a hardware vector is presented or a hardware service is on the stack. Software trap services alone leave it at 1.
- R12: While `vec_valid_o`=1 and `vec_ready_i`=0, the vector outputs stay stable. The level is pushed on acceptance and popped on `rett_i`. A `rett_i` with an empty stack is ignored.
- R13: After a software request is accepted, `sw_ready_o` stays 0 until that request has been moved to the vector output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_cause_i | input | 3 | Reset-source pulses (power-on, software, watchdog) |
| cls_a_i | input | 3 | Level-2 trap pulses: NMI, stack overflow, stack underflow |
| cls_b_i | input | 5 | Level-1 fault pulses |
| sw_valid_i | input | 1 | Software trap request valid |
| sw_num_i | input | 7 | Software trap number |
| sw_ready_o | output | 1 | Software trap request can be taken |
| vec_valid_o | output | 1 | Vector request presented |
| vec_ready_i | input | 1 | Core accepts the vector |
| vec_addr_o | output | 24 | Vector address |
| vec_num_o | output | 7 | Trap number |
| vec_level_o | output | 2 | Level the service will run at |
| rett_i | input | 1 | Return-from-trap pulse, pops one level |
| std_irq_ok_o | output | 1 | Ordinary interrupts permitted |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_mask_i | input | 8 | Write-one-to-clear mask |
| flags_o | output | 8 | Trap flag register |

## Verification
The assertions assume three things about the inputs: trap and reset pulses last one cycle, `rett_i` is raised only to end a service that the core accepted, and the software trap number is steady while `sw_valid_i` is high. The stimulus meets these assumptions. All inputs change at the falling edge. A vector is acknowledged only after `vec_valid_o` has been seen high. Every accepted vector is matched by exactly one return, except in the single case that checks a return on an empty stack.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NUM_A   = 3;
  localparam int NUM_B   = 5;
  localparam int NUM_RST = 3;
  localparam int FLAG_W  = NUM_A + NUM_B;
  localparam int NUM_W   = 7;
  localparam int HW_LEVELS = 3;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_I    = 2'd1;
  localparam lvl_t LVL_II   = 2'd2;
  localparam lvl_t LVL_III  = 2'd3;

  localparam logic [NUM_W-1:0] NUM_RESET = 7'h00;
  localparam logic [NUM_W-1:0] NUM_FAULT = 7'h0A;

  typedef struct packed {
    logic             hw;
    lvl_t             lvl;
    logic [NUM_W-1:0] num;
  } trap_req_t;

  function automatic logic [NUM_W-1:0] urgent_num(input int idx);
    return NUM_W'(2 * (idx + 1));
  endfunction
endpackage

// File: rtl/trap_flags.sv
module trap_flags
  import trap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_RST-1:0] rst_cause_i,
  input  logic [NUM_A-1:0]  set_a_i,
  input  logic [NUM_B-1:0]  set_b_i,
  input  logic              clr_we_i,
  input  logic [FLAG_W-1:0] clr_mask_i,
  input  logic              take_rst_i,
  input  logic [NUM_A-1:0]  take_a_i,
  input  logic              take_b_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              pend_rst_o,
  output logic [NUM_A-1:0]  pend_a_o,
  output logic              pend_b_o
);
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;

  assign set_vec = {set_b_i, set_a_i};
  assign clr_vec = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o    <= '0;
      pend_rst_o <= 1'b0;
      pend_a_o   <= '0;
      pend_b_o   <= 1'b0;
    end else begin
      flags_o    <= (flags_o & ~clr_vec) | set_vec;
      pend_rst_o <= (pend_rst_o & ~take_rst_i) | (|rst_cause_i);
      pend_a_o   <= (pend_a_o & ~take_a_i) | set_a_i;
      pend_b_o   <= (pend_b_o & ~take_b_i) | (|set_b_i);
    end
  end

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[g] |=> flags_o[g]); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_o[g] && !clr_vec[g] |=> flags_o[g]); // R5
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_b_o && !take_b_i |=> pend_b_o); // R8
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic             pend_rst_i,
  input  logic [NUM_A-1:0] pend_a_i,
  input  logic             pend_b_i,
  input  logic             sw_pend_i,
  input  logic [NUM_W-1:0] sw_num_i,
  input  lvl_t             cur_lvl_i,
  output logic             sel_valid_o,
  output trap_req_t        sel_o,
  output logic             take_rst_o,
  output logic [NUM_A-1:0] take_a_o,
  output logic             take_b_o,
  output logic             take_sw_o
);
  logic hit;

  always_comb begin
    sel_valid_o = 1'b0;
    sel_o       = '0;
    take_rst_o  = 1'b0;
    take_a_o    = '0;
    take_b_o    = 1'b0;
    take_sw_o   = 1'b0;
    hit         = 1'b0;
    if (pend_rst_i && (LVL_III > cur_lvl_i)) begin
      sel_valid_o = 1'b1;
      sel_o.hw    = 1'b1;
      sel_o.lvl   = LVL_III;
      sel_o.num   = NUM_RESET;
      take_rst_o  = 1'b1;
    end else if ((|pend_a_i) && (LVL_II > cur_lvl_i)) begin
      sel_valid_o = 1'b1;
      sel_o.hw    = 1'b1;
      sel_o.lvl   = LVL_II;
      for (int i = 0; i < NUM_A; i++) begin
        if (pend_a_i[i] && !hit) begin
          hit         = 1'b1;
          take_a_o[i] = 1'b1;
          sel_o.num   = urgent_num(i);
        end
      end
    end else if (pend_b_i && (LVL_I > cur_lvl_i)) begin
      sel_valid_o = 1'b1;
      sel_o.hw    = 1'b1;
      sel_o.lvl   = LVL_I;
      sel_o.num   = NUM_FAULT;
      take_b_o    = 1'b1;
    end else if (sw_pend_i) begin
      sel_valid_o = 1'b1;
      sel_o.hw    = 1'b0;
      sel_o.lvl   = cur_lvl_i;
      sel_o.num   = sw_num_i;
      take_sw_o   = 1'b1;
    end
  end

  always_comb begin
    assert ($onehot0({take_rst_o, take_a_o, take_b_o, take_sw_o}))
      else $error("AST_ONE_TAKE"); // R4
  end
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
  import trap_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RESERVE = HW_LEVELS + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic push_hw_i,
  input  logic pop_i,
  output lvl_t cur_lvl_o,
  output logic hw_active_o,
  output logic room_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t             lvl_q [DEPTH];
  logic             hw_q  [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] hw_cnt_q;
  logic [CNT_W-1:0] top_idx;
  logic [CNT_W-1:0] wr_idx;
  logic             pop_eff;
  logic             pop_hw;

  assign pop_eff = pop_i && (count_q != '0);
  assign top_idx = count_q - CNT_W'(1);
  assign wr_idx  = count_q - CNT_W'(pop_eff);
  assign pop_hw  = pop_eff && hw_q[top_idx[IDX_W-1:0]];

  assign cur_lvl_o   = (count_q == '0) ? LVL_NONE : lvl_q[top_idx[IDX_W-1:0]];
  assign hw_active_o = (hw_cnt_q != '0);
  assign room_o      = (count_q <= CNT_W'(DEPTH - RESERVE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      hw_cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lvl_q[i] <= LVL_NONE;
        hw_q[i]  <= 1'b0;
      end
    end else begin
      count_q  <= count_q + CNT_W'(push_i) - CNT_W'(pop_eff);
      hw_cnt_q <= hw_cnt_q + CNT_W'(push_i && push_hw_i) - CNT_W'(pop_hw);
      if (push_i) begin
        lvl_q[wr_idx[IDX_W-1:0]] <= push_lvl_i;
        hw_q[wr_idx[IDX_W-1:0]]  <= push_hw_i;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_eff |-> count_q < CNT_W'(DEPTH)); // R12
  AST_EMPTY_RETT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && (count_q == '0) |=> count_q == '0); // R12
  AST_HW_NESTS_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && push_hw_i && !pop_eff |-> push_lvl_i > cur_lvl_o); // R7
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        rst_cause_i,
  input  logic [2:0]        cls_a_i,
  input  logic [4:0]        cls_b_i,
  input  logic              sw_valid_i,
  input  logic [6:0]        sw_num_i,
  output logic              sw_ready_o,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [6:0]        vec_num_o,
  output logic [1:0]        vec_level_o,
  input  logic              rett_i,
  output logic              std_irq_ok_o,
  input  logic              flag_clr_we_i,
  input  logic [7:0]        flag_clr_mask_i,
  output logic [7:0]        flags_o
);
  localparam int PAD_W = ADDR_W - NUM_W - 2;

  logic             pend_rst, pend_b;
  logic [NUM_A-1:0] pend_a;
  logic             sel_valid;
  trap_req_t        sel;
  logic             take_rst, take_b, take_sw;
  logic [NUM_A-1:0] take_a;
  logic             load, accept;
  lvl_t             cur_lvl;
  logic             hw_active, room;
  logic             sw_pend_q;
  logic [NUM_W-1:0] sw_num_q;
  logic             vec_valid_q;
  trap_req_t        req_q;

  assign load   = !vec_valid_q && sel_valid;
  assign accept = vec_valid_q && vec_ready_i;

  trap_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_cause_i (rst_cause_i),
    .set_a_i     (cls_a_i),
    .set_b_i     (cls_b_i),
    .clr_we_i    (flag_clr_we_i),
    .clr_mask_i  (flag_clr_mask_i),
    .take_rst_i  (take_rst && load),
    .take_a_i    (take_a & {NUM_A{load}}),
    .take_b_i    (take_b && load),
    .flags_o     (flags_o),
    .pend_rst_o  (pend_rst),
    .pend_a_o    (pend_a),
    .pend_b_o    (pend_b)
  );

  trap_arbiter u_arb (
    .pend_rst_i  (pend_rst),
    .pend_a_i    (pend_a),
    .pend_b_i    (pend_b),
    .sw_pend_i   (sw_pend_q),
    .sw_num_i    (sw_num_q),
    .cur_lvl_i   (cur_lvl),
    .sel_valid_o (sel_valid),
    .sel_o       (sel),
    .take_rst_o  (take_rst),
    .take_a_o    (take_a),
    .take_b_o    (take_b),
    .take_sw_o   (take_sw)
  );

  trap_level_stack #(
    .DEPTH   (STACK_DEPTH),
    .RESERVE (HW_LEVELS + 1)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (accept),
    .push_lvl_i  (req_q.lvl),
    .push_hw_i   (req_q.hw),
    .pop_i       (rett_i),
    .cur_lvl_o   (cur_lvl),
    .hw_active_o (hw_active),
    .room_o      (room)
  );

  assign sw_ready_o = !sw_pend_q && room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_pend_q <= 1'b0;
      sw_num_q  <= '0;
    end else if (sw_valid_i && sw_ready_o) begin
      sw_pend_q <= 1'b1;
      sw_num_q  <= sw_num_i;
    end else if (take_sw && load) begin
      sw_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_q <= 1'b0;
      req_q       <= '0;
    end else if (load) begin
      vec_valid_q <= 1'b1;
      req_q       <= sel;
    end else if (accept) begin
      vec_valid_q <= 1'b0;
    end
  end

  assign vec_valid_o  = vec_valid_q;
  assign vec_num_o    = req_q.num;
  assign vec_level_o  = req_q.lvl;
  assign vec_addr_o   = {{PAD_W{1'b0}}, req_q.num, 2'b00};
  assign std_irq_ok_o = !hw_active && !(vec_valid_q && req_q.hw);

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_q && !vec_ready_i |=> vec_valid_q && $stable(req_q)); // R12
  AST_NO_RSVD_NUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_q && req_q.hw |-> !(req_q.num >= 7'h0B && req_q.num <= 7'h0F)); // R10
  AST_PREEMPT_ONLY_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_q && req_q.hw |-> req_q.lvl > cur_lvl); // R7
  AST_STD_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && req_q.hw && !rett_i |=> !std_irq_ok_o); // R11
  AST_RESET_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_q && req_q.hw && (req_q.num == NUM_RESET) |-> req_q.lvl == LVL_III); // R2
  AST_SW_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_i && sw_ready_o |=> !sw_ready_o); // R13
endmodule

// File: tb/trap_vector_unit_bench.sv
module trap_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rst_cause = '0;
  logic [2:0]  cls_a = '0;
  logic [4:0]  cls_b = '0;
  logic        sw_valid = 1'b0;
  logic [6:0]  sw_num = '0;
  logic        sw_ready;
  logic        vec_valid;
  logic        vec_ready = 1'b0;
  logic [23:0] vec_addr;
  logic [6:0]  vec_num;
  logic [1:0]  vec_level;
  logic        rett = 1'b0;
  logic        std_ok;
  logic        clr_we = 1'b0;
  logic [7:0]  clr_mask = '0;
  logic [7:0]  flags;
  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trap_vector_unit u_trap_vector_unit (
    .clk_i(clk), .rst_ni(rst_n), .rst_cause_i(rst_cause), .cls_a_i(cls_a),
    .cls_b_i(cls_b), .sw_valid_i(sw_valid), .sw_num_i(sw_num),
    .sw_ready_o(sw_ready), .vec_valid_o(vec_valid), .vec_ready_i(vec_ready),
    .vec_addr_o(vec_addr), .vec_num_o(vec_num), .vec_level_o(vec_level),
    .rett_i(rett), .std_irq_ok_o(std_ok), .flag_clr_we_i(clr_we),
    .flag_clr_mask_i(clr_mask), .flags_o(flags)
  );

  // {rst_cause[2:0], cls_a[2:0], cls_b[4:0], exp_num[6:0], exp_lvl[1:0]}
  localparam int NV = 9;
  localparam logic [19:0] VEC_TAB [NV] = '{
    {3'b001, 3'b000, 5'b00000, 7'h00, 2'd3},
    {3'b100, 3'b000, 5'b00000, 7'h00, 2'd3},
    {3'b000, 3'b001, 5'b00000, 7'h02, 2'd2},
    {3'b000, 3'b010, 5'b00000, 7'h04, 2'd2},
    {3'b000, 3'b100, 5'b00000, 7'h06, 2'd2},
    {3'b000, 3'b000, 5'b00001, 7'h0A, 2'd1},
    {3'b000, 3'b000, 5'b10000, 7'h0A, 2'd1},
    {3'b000, 3'b000, 5'b01110, 7'h0A, 2'd1},
    {3'b000, 3'b000, 5'b11111, 7'h0A, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic take(input int num, input int lvl, input string req);
    int seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      if (vec_valid) seen = 1; else @(negedge clk);
    end
    chk(seen == 1, {req, " valid"}, seen, 1);
    chk(vec_num == 7'(num), {req, " num"}, vec_num, num);
    chk(vec_addr == 24'(num * 4), {req, " addr"}, vec_addr, num * 4);
    chk(vec_level == 2'(lvl), {req, " level"}, vec_level, lvl);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic ret();
    rett = 1'b1;
    @(negedge clk);
    rett = 1'b0;
  endtask

  task automatic no_vec(input int cycles, input string req);
    int got = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (vec_valid) got = 1;
    end
    chk(got == 0, req, got, 0);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_mask = 8'hFF;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
    chk(flags == 0, "R1 flags", flags, 0);
    chk(std_ok == 1, "R1 std_irq_ok", std_ok, 1);
    chk(sw_ready == 1, "R1 sw_ready", sw_ready, 1);

    // Table walk: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      rst_cause = VEC_TAB[k][19:17];
      cls_a     = VEC_TAB[k][16:14];
      cls_b     = VEC_TAB[k][13:9];
      @(negedge clk);
      rst_cause = '0; cls_a = '0; cls_b = '0;
      chk(flags == {VEC_TAB[k][13:9], VEC_TAB[k][16:14]}, "R5 flag bits",
          flags, {VEC_TAB[k][13:9], VEC_TAB[k][16:14]});
      take(VEC_TAB[k][8:2], VEC_TAB[k][1:0], "R2/R3/R4 table");
      chk(VEC_TAB[k][8:2] < 7'h0B || VEC_TAB[k][8:2] > 7'h0F, "R10 hw num", vec_num, 0);
      ret();
      no_vec(3, "R4 merged faults single vector");
      chk(flags == {VEC_TAB[k][13:9], VEC_TAB[k][16:14]}, "R5 flags held",
          flags, {VEC_TAB[k][13:9], VEC_TAB[k][16:14]});
      clear_all();
      chk(flags == 0, "R6 clear all", flags, 0);
    end

    // R3 order within class A, R4 level 2 before level 1
    cls_a = 3'b110; cls_b = 5'b00100;
    @(negedge clk);
    cls_a = '0; cls_b = '0;
    take(7'h04, 2, "R3 overflow first");
    ret();
    take(7'h06, 2, "R3 underflow next");
    ret();
    take(7'h0A, 1, "R4 fault last");
    ret();
    clear_all();

    // R6 partial clear and set-wins
    cls_a = 3'b001; cls_b = 5'b00001;
    @(negedge clk);
    cls_a = '0; cls_b = '0;
    chk(flags == 8'h09, "R6 set two", flags, 8'h09);
    clr_we = 1'b1; clr_mask = 8'h01;
    @(negedge clk);
    chk(flags == 8'h08, "R6 masked clear", flags, 8'h08);
    clr_mask = 8'h08; cls_b = 5'b00001;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0; cls_b = '0;
    chk(flags == 8'h08, "R6 set wins over clear", flags, 8'h08);
    take(7'h02, 2, "R4 NMI before fault");
    ret();
    take(7'h0A, 1, "R4 fault after NMI");
    ret();
    no_vec(3, "R4 repeated fault merged");
    clear_all();

    // R7 preempt, R8 no preempt, R11 qualifier
    cls_b = 5'b01000;
    @(negedge clk);
    cls_b = '0;
    repeat (2) @(negedge clk);
    chk(std_ok == 0, "R11 blocked while presented", std_ok, 0);
    take(7'h0A, 1, "R7 fault service");
    chk(std_ok == 0, "R11 blocked in service", std_ok, 0);
    cls_a = 3'b001;
    @(negedge clk);
    cls_a = '0;
    take(7'h02, 2, "R7 NMI preempts");
    cls_b = 5'b00010;
    @(negedge clk);
    cls_b = '0;
    no_vec(5, "R8 fault waits under NMI");
    chk(flags[4] == 1, "R8 flag still set", flags[4], 1);
    ret();
    no_vec(4, "R8 fault waits under fault");
    ret();
    take(7'h0A, 1, "R8 fault after return");
    ret();
    @(negedge clk);
    chk(std_ok == 1, "R11 released", std_ok, 1);
    clear_all();

    // R12 back-pressure stability
    cls_a = 3'b100;
    @(negedge clk);
    cls_a = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(vec_valid && vec_num == 7'h06 && vec_level == 2'd2, "R12 held",
          vec_num, 7'h06);
    end
    take(7'h06, 2, "R12 accept");
    ret();
    clear_all();

    // R12 return on empty stack ignored
    ret();
    ret();
    cls_b = 5'b00001;
    @(negedge clk);
    cls_b = '0;
    take(7'h0A, 1, "R12 empty rett ignored");
    ret();
    clear_all();

    // R9 software trap, R13 ready
    sw_valid = 1'b1; sw_num = 7'h7F;
    @(negedge clk);
    sw_valid = 1'b0;
    chk(sw_ready == 0, "R13 ready low while pending", sw_ready, 0);
    take(7'h7F, 0, "R9 sw top number");
    chk(std_ok == 1, "R11 sw service keeps ok", std_ok, 1);
    chk(sw_ready == 1, "R13 ready back", sw_ready, 1);
    ret();

    // R9 software trap inherits running level
    cls_b = 5'b00001;
    @(negedge clk);
    cls_b = '0;
    take(7'h0A, 1, "R9 enter fault");
    sw_valid = 1'b1; sw_num = 7'h10;
    @(negedge clk);
    sw_valid = 1'b0;
    take(7'h10, 1, "R9 sw inherits level 1");
    ret();
    ret();

    // R9 hardware before software in same cycle
    sw_valid = 1'b1; sw_num = 7'h33; cls_a = 3'b001;
    @(negedge clk);
    sw_valid = 1'b0; cls_a = '0;
    take(7'h02, 2, "R9 NMI first");
    take(7'h33, 2, "R9 sw at level 2");
    ret();
    ret();
    clear_all();
    no_vec(3, "R12 idle at end");

    report();
  end
endmodule